// File: doc/BRIEF.md
# Receive Character Queue with Line Status

This block sits between a serial receiver and the register port a processor reads. A character arrives as a one-cycle strobe. It carries eight data bits and three quality flags: parity error, framing error and break. The block stores the character and its flags together in a first-in first-out queue of up to sixteen entries. The flags shown at the outputs always belong to the character at the head of the queue. A read of the receive holding register removes the head. A read of the status register clears the sticky status bits.

The block raises a level-sensitive data request once the fill level reaches a selectable threshold. It also runs an idle timer, so that a few characters below the threshold still get noticed. A control write enables or disables queueing, selects the threshold and can flush the stored characters. When the queue is disabled, storage shrinks to a single holding slot.

Top module: `rxq_top`

## Requirements
- R1: With `cfg_en`=1 the queue holds 16 characters. With `cfg_en`=0 it holds one, so a second character that arrives before a holding read is an overrun. Any write that changes the enable state empties the queue.
- R2: A control write with `ctl_en`=0 clears the enable and leaves `cfg_trig` unchanged, whatever `ctl_trig` and `ctl_rx_clr` carry. A write with `ctl_en`=1 loads `ctl_trig`. The reset values are enable 0 and trigger code 0.
- R3: The trigger code maps 0→1, 1→4, 2→8 and 3→14 characters. `rx_req` is 1 exactly while the fill level is at or above that count. When disabled, the count is 1. The queue keeps accepting characters above the threshold until it is full.
- R4: A control write with `ctl_en`=1 and `ctl_rx_clr`=1 empties the queue in the next cycle. The clear is a pulse and is not stored.
- R5: A character that arrives while the queue is full sets `ovr_err` and is discarded, and the stored characters are unchanged. A status read clears `ovr_err`. A new overrun in the same cycle wins over the clear.
- R6: `head_perr`, `head_ferr` and `head_brk` show the flags stored with the head character, and they are 0 when the queue is empty.
- R7: While a break persists, the receiver strobes a character with `chr_brk`=1 once per frame time. Only the first of such a consecutive run is stored. A character with `chr_brk`=0 ends the run.
- R8: `err_any` sets when a character with any flag is stored. It stays set until a status read or a flush, and a store in the same cycle wins over the clear.
- R9: `data_rdy` is 1 from the cycle after a character is stored until the queue becomes empty.
- R10: The idle timer restarts on `stop_mid` and on a holding read. It is held at zero while the queue is empty, so `rx_tmo` never sets with nothing stored.
- R11: `rx_tmo` sets once the timer passes 4×`char_ticks` clock cycles without a restart. A holding read or a flush clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chr_valid | input | 1 | One-cycle strobe: a received character is complete |
| chr_data | input | 8 | Received data byte |
| chr_perr | input | 1 | Parity error for this character |
| chr_ferr | input | 1 | Framing error for this character |
| chr_brk | input | 1 | Character is a break frame |
| stop_mid | input | 1 | Receiver is at the middle of a stop bit |
| char_ticks | input | 16 | Clock cycles per character time |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Written queue enable |
| ctl_rx_clr | input | 1 | Written flush request (honoured only with ctl_en=1) |
| ctl_trig | input | 2 | Written trigger code |
| hold_rd | input | 1 | Holding register read: pops the head |
| stat_rd | input | 1 | Status register read: clears sticky bits |
| cfg_en | output | 1 | Current queue enable |
| cfg_trig | output | 2 | Current trigger code |
| hold_data | output | 8 | Head character data |
| fill_level | output | 5 | Characters stored |
| data_rdy | output | 1 | Queue not empty |
| ovr_err | output | 1 | Sticky overrun |
| head_perr | output | 1 | Head character parity flag |
| head_ferr | output | 1 | Head character framing flag |
| head_brk | output | 1 | Head character break flag |
| err_any | output | 1 | Sticky summary of stored flagged characters |
| rx_req | output | 1 | Fill level at or above threshold |
| rx_tmo | output | 1 | Idle timeout pending |

## Verification
On every cycle, the assertions check the fill count bounds and its step on a lone store, that a full-queue arrival raises the overrun, that a flush empties the queue, and that the request never stands on an empty queue. They also check that the timeout never stands while the queue is empty and drops after a holding read. The bench scenarios are needed for the rest. They cover the trigger mapping at each boundary, the order of data with its flags, the collapse of a break run to one entry, the single-slot behaviour when disabled, the ignored fields of a disabling write, and the exact length of the timeout and its restart by `stop_mid`.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rxq_entry_t;

    function automatic int unsigned trig_count(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic            flush,
    input  rxq_entry_t      wr_entry,
    output rxq_entry_t      head,
    output logic [CW-1:0]   count
);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_q, st_d;
    rxq_entry_t mem_q [DEPTH];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push) st_d.wp = nxt(st_q.wp);
            if (pop)  st_d.rp = nxt(st_q.rp);
            if (push && !pop)      st_d.cnt = st_q.cnt + 1'b1;
            else if (pop && !push) st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem_q[st_q.wp] <= wr_entry;
    end

    assign head  = mem_q[st_q.rp];
    assign count = st_q.cnt;

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush) |=> (st_q.cnt == $past(st_q.cnt) + CW'(1)));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int TW = 16,
    localparam int LW = TW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] char_ticks,
    input  logic          active,
    input  logic          restart,
    input  logic          clear,
    output logic          timeout
);

    typedef struct packed {
        logic [LW-1:0] cnt;
        logic          fire;
    } tm_t;

    tm_t tm_q, tm_d;
    logic [LW-1:0] limit;

    assign limit = {char_ticks, 2'b00};

    always_comb begin
        tm_d = tm_q;
        if (!active || restart)  tm_d.cnt = '0;
        else if (tm_q.cnt != limit) tm_d.cnt = tm_q.cnt + 1'b1;

        if (clear)
            tm_d.fire = 1'b0;
        else if (active && !restart && tm_q.cnt == limit)
            tm_d.fire = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign timeout = tm_q.fire;

    p_tmo_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !timeout);

endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TW    = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chr_valid,
    input  logic [7:0]    chr_data,
    input  logic          chr_perr,
    input  logic          chr_ferr,
    input  logic          chr_brk,
    input  logic          stop_mid,
    input  logic [TW-1:0] char_ticks,
    input  logic          ctl_wr,
    input  logic          ctl_en,
    input  logic          ctl_rx_clr,
    input  logic [1:0]    ctl_trig,
    input  logic          hold_rd,
    input  logic          stat_rd,
    output logic          cfg_en,
    output logic [1:0]    cfg_trig,
    output logic [7:0]    hold_data,
    output logic [CW-1:0] fill_level,
    output logic          data_rdy,
    output logic          ovr_err,
    output logic          head_perr,
    output logic          head_ferr,
    output logic          head_brk,
    output logic          err_any,
    output logic          rx_req,
    output logic          rx_tmo
);

    typedef struct packed {
        logic       en;
        logic [1:0] trig;
        logic       ovr;
        logic       err;
        logic       brk_run;
    } ctl_t;

    ctl_t c_q, c_d;

    rxq_entry_t wr_entry, head;
    logic [CW-1:0] count;
    logic flush, accept, full, push, pop, has_flag;
    logic [CW-1:0] lim, thr;

    assign wr_entry = '{brk: chr_brk, ferr: chr_ferr, perr: chr_perr, data: chr_data};
    assign has_flag = chr_perr | chr_ferr | chr_brk;
    assign lim      = c_q.en ? CW'(DEPTH) : CW'(1);
    assign thr      = c_q.en ? CW'(trig_count(c_q.trig)) : CW'(1);
    assign full     = (count >= lim);
    assign pop      = hold_rd && (count != '0) && !flush;
    assign accept   = chr_valid && !(chr_brk && c_q.brk_run);
    assign push     = accept && (!full || pop) && !flush;

    always_comb begin
        c_d   = c_q;
        flush = 1'b0;
        if (ctl_wr) begin
            if (ctl_en) begin
                c_d.en   = 1'b1;
                c_d.trig = ctl_trig;
                flush    = ctl_rx_clr || !c_q.en;
            end else begin
                c_d.en = 1'b0;
                flush  = c_q.en;
            end
        end

        if (chr_valid) c_d.brk_run = chr_brk;

        if (accept && full && !pop && !flush) c_d.ovr = 1'b1;
        else if (stat_rd)                     c_d.ovr = 1'b0;

        if (push && has_flag)      c_d.err = 1'b1;
        else if (stat_rd || flush) c_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .flush    (flush),
        .wr_entry (wr_entry),
        .head     (head),
        .count    (count)
    );

    rxq_timer #(.TW(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_ticks (char_ticks),
        .active     (count != '0),
        .restart    (stop_mid || hold_rd),
        .clear      (hold_rd || flush),
        .timeout    (rx_tmo)
    );

    assign cfg_en     = c_q.en;
    assign cfg_trig   = c_q.trig;
    assign fill_level = count;
    assign data_rdy   = (count != '0);
    assign hold_data  = head.data;
    assign head_perr  = data_rdy & head.perr;
    assign head_ferr  = data_rdy & head.ferr;
    assign head_brk   = data_rdy & head.brk;
    assign ovr_err    = c_q.ovr;
    assign err_any    = c_q.err;
    assign rx_req     = (count >= thr);

    p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && !chr_brk && count == CW'(DEPTH) && c_q.en && !hold_rd && !ctl_wr)
        |=> ovr_err);

    p_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_en && ctl_rx_clr) |=> (fill_level == '0));

    p_req_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req |-> data_rdy);

    p_tmo_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tmo |-> data_rdy);

endmodule

// File: tb/rxq_top_tb_top.sv
module rxq_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {brk, ferr, perr, data}
    localparam logic [10:0] VEC [NVEC] = '{
        {3'b000, 8'h41}, {3'b001, 8'h42}, {3'b010, 8'h43}, {3'b000, 8'h00},
        {3'b011, 8'hFF}, {3'b000, 8'h5A}, {3'b001, 8'hA5}, {3'b000, 8'h7E}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chr_valid = 0, chr_perr = 0, chr_ferr = 0, chr_brk = 0, stop_mid = 0;
    logic [7:0] chr_data = '0;
    logic [15:0] char_ticks = 16'd5;
    logic ctl_wr = 0, ctl_en = 0, ctl_rx_clr = 0;
    logic [1:0] ctl_trig = '0;
    logic hold_rd = 0, stat_rd = 0;
    logic cfg_en, data_rdy, ovr_err, head_perr, head_ferr, head_brk, err_any, rx_req, rx_tmo;
    logic [1:0] cfg_trig;
    logic [7:0] hold_data;
    logic [4:0] fill_level;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_top dut_i (
        .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
        .chr_perr(chr_perr), .chr_ferr(chr_ferr), .chr_brk(chr_brk), .stop_mid(stop_mid),
        .char_ticks(char_ticks), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_rx_clr(ctl_rx_clr),
        .ctl_trig(ctl_trig), .hold_rd(hold_rd), .stat_rd(stat_rd), .cfg_en(cfg_en),
        .cfg_trig(cfg_trig), .hold_data(hold_data), .fill_level(fill_level),
        .data_rdy(data_rdy), .ovr_err(ovr_err), .head_perr(head_perr), .head_ferr(head_ferr),
        .head_brk(head_brk), .err_any(err_any), .rx_req(rx_req), .rx_tmo(rx_tmo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic pe, input logic fe, input logic bk);
        @(negedge clk);
        chr_valid = 1; chr_data = d; chr_perr = pe; chr_ferr = fe; chr_brk = bk; stop_mid = 1;
        @(negedge clk);
        chr_valid = 0; chr_perr = 0; chr_ferr = 0; chr_brk = 0; stop_mid = 0;
    endtask

    task automatic hread();
        @(negedge clk); hold_rd = 1;
        @(negedge clk); hold_rd = 0;
    endtask

    task automatic sread();
        @(negedge clk); stat_rd = 1;
        @(negedge clk); stat_rd = 0;
    endtask

    task automatic cwrite(input logic en, input logic clr, input logic [1:0] trg);
        @(negedge clk); ctl_wr = 1; ctl_en = en; ctl_rx_clr = clr; ctl_trig = trg;
        @(negedge clk); ctl_wr = 0; ctl_en = 0; ctl_rx_clr = 0; ctl_trig = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk("R9 reset data_rdy", data_rdy, 0);
        chk("R2 reset cfg", {cfg_en, cfg_trig}, 0);
        chk("R5 reset ovr", ovr_err, 0);
        chk("R11 reset tmo", rx_tmo, 0);

        // R1 disabled: single slot
        push(8'h11, 0, 0, 0);
        chk("R9 data_rdy after store", data_rdy, 1);
        chk("R3 req at 1 when disabled", rx_req, 1);
        push(8'h22, 0, 0, 0);
        chk("R1 single slot overrun", ovr_err, 1);
        chk("R1 single slot fill", fill_level, 1);
        chk("R5 stored data intact", hold_data, 8'h11);
        sread();
        chk("R5 status read clears ovr", ovr_err, 0);
        hread();
        chk("R9 empty after read", data_rdy, 0);

        // R2 disabling write ignores trigger
        cwrite(0, 1, 2'd3);
        chk("R2 disabled write keeps trig", {cfg_en, cfg_trig}, 0);

        // R3 threshold 4
        cwrite(1, 0, 2'd1);
        chk("R2 enabled write loads trig", {cfg_en, cfg_trig}, 3'b101);
        for (int i = 0; i < 3; i++) push(8'(i), 0, 0, 0);
        chk("R3 below 4 no req", rx_req, 0);
        push(8'h03, 0, 0, 0);
        chk("R3 at 4 req", rx_req, 1);
        hread();
        chk("R3 below 4 after read", rx_req, 0);
        cwrite(1, 1, 2'd1);
        chk("R4 flush empties", fill_level, 0);
        chk("R4 trig kept", cfg_trig, 2'd1);

        // table-driven store and drain, threshold 8
        cwrite(1, 0, 2'd2);
        for (int i = 0; i < NVEC; i++) begin
            push(VEC[i][7:0], VEC[i][8], VEC[i][9], VEC[i][10]);
            chk("R9 fill step", fill_level, 5'(i + 1));
            chk("R3 req vs 8", rx_req, (i + 1 >= 8));
        end
        chk("R8 summary set", err_any, 1);
        sread();
        chk("R8 status read clears", err_any, 0);
        for (int i = 0; i < NVEC; i++) begin
            chk("R6 head data", hold_data, VEC[i][7:0]);
            chk("R6 head flags", {head_brk, head_ferr, head_perr}, VEC[i][10:8]);
            hread();
        end
        chk("R6 flags zero when empty", {head_brk, head_ferr, head_perr}, 0);

        // R7 break run
        push(8'h00, 0, 1, 1);
        push(8'h00, 0, 1, 1);
        push(8'h00, 0, 1, 1);
        chk("R7 one break stored", fill_level, 1);
        push(8'h33, 0, 0, 0);
        chk("R7 run ends", fill_level, 2);
        chk("R7 head is break", head_brk, 1);
        hread();
        chk("R7 next head data", hold_data, 8'h33);
        hread();

        // R5 full queue
        for (int i = 0; i < 16; i++) push(8'(i + 8'h80), 0, 0, 0);
        chk("R1 holds 16", fill_level, 16);
        chk("R5 no ovr at full", ovr_err, 0);
        push(8'hEE, 0, 0, 0);
        chk("R5 ovr on full", ovr_err, 1);
        chk("R5 fill unchanged", fill_level, 16);
        chk("R5 head intact", hold_data, 8'h80);
        cwrite(1, 1, 2'd0);
        sread();

        // R10 / R11 timeout, char_ticks = 5 => 20 cycles
        repeat (40) @(negedge clk);
        chk("R10 no timeout when empty", rx_tmo, 0);
        push(8'h55, 0, 0, 0);
        repeat (18) @(negedge clk);
        chk("R11 not yet timed out", rx_tmo, 0);
        repeat (4) @(negedge clk);
        chk("R11 timeout fires", rx_tmo, 1);
        hread();
        chk("R11 read clears tmo", rx_tmo, 0);
        push(8'h56, 0, 0, 0);
        repeat (15) @(negedge clk);
        push(8'h57, 0, 0, 0);
        repeat (15) @(negedge clk);
        chk("R10 stop_mid restarts", rx_tmo, 0);
        repeat (8) @(negedge clk);
        chk("R10 fires after restart", rx_tmo, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule